// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block judges whether a phase-locked loop has settled. It watches the up and down pulses that a phase-frequency detector produces once per comparison cycle. It resynchronizes both pulses into a fast sampling clock domain. It then counts how many sampling ticks each error pulse lasts. When that pulse ends, the finished comparison is classified against two tick thresholds. The lower threshold is the entry limit, nominally 15 ns of phase error. The upper threshold is the exit limit, nominally 25 ns.

The active-high lock output is raised only after enough clean comparisons arrive back to back. A static select input chooses how many are needed: a short run or a long run. Once raised, lock is dropped only by a single comparison whose error exceeds the exit limit. The gap between the two limits gives the output hysteresis.

A comparison cycle is defined as one pulse of the combined error signal, that is, up OR down, as seen after synchronization. The measured width is the number of sampling edges at which that combined signal was high.

Top module: `pll_lock_detect`

## Requirements
- R1: While `rst_n` is low, `lock_o` is 0 and the count of consecutive clean comparisons is cleared. Clean comparisons seen before a reset do not count toward lock after it.
- R2: A comparison's width is the number of sampling ticks during which `up_i` or `dn_i` (either one, or both overlapping) was high. A pulse on `dn_i` alone is measured in the same way as one on `up_i`.
- R3: With `precise_i` = 0, `lock_o` rises after exactly 3 consecutive comparisons whose width is below `ENTRY_TICKS` (default 15).
- R4: With `precise_i` = 1, `lock_o` rises after exactly 5 consecutive such comparisons; 4 are not enough.
- R5: While locked, a comparison whose width is at least `ENTRY_TICKS` and at most `EXIT_TICKS` (default 25) keeps `lock_o` at 1. A clean comparison also keeps `lock_o` at 1.
- R6: While locked, one comparison whose width is above `EXIT_TICKS` clears `lock_o`.
- R7: While unlocked, any comparison of width `ENTRY_TICKS` or more restarts the consecutive count from zero.
- R8: A width equal to `ENTRY_TICKS` is not clean. A width equal to `EXIT_TICKS` does not clear lock.
- R9: Both pulse inputs pass through two flip-flop stages. As a result, `lock_o` changes at the third rising clock edge after the first edge that samples the ending pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock; one period is one tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_i | input | 1 | Phase detector up pulse, asynchronous |
| dn_i | input | 1 | Phase detector down pulse, asynchronous |
| precise_i | input | 1 | 0: three clean comparisons to lock; 1: five |
| lock_o | output | 1 | Active-high lock indication |

## Verification
On every cycle, the assertions check several properties. Lock can only rise right after a clean comparison, and only fall right after one wider than the exit limit. Lock holds through any comparison that is not over the exit limit. The unlocked run count is zeroed by a comparison that is not clean. Each measurement strobe is a single cycle and carries a nonzero width.

Some behaviours only the bench's scenarios can show. These are the exact number of comparisons needed in each precision mode and the treatment of widths exactly at each limit. The bench also shows how overlapping up and down pulses merge into one width, and that the lock output appears at the third edge after a pulse ends.

// File: rtl/pld_pkg.sv
package pld_pkg;
   typedef enum logic [1:0] {
      PLD_CLEAN = 2'd0,
      PLD_MID   = 2'd1,
      PLD_WIDE  = 2'd2
   } pld_verdict_e;

   function automatic pld_verdict_e pld_classify(input int unsigned width,
                                                 input int unsigned entry_lim,
                                                 input int unsigned exit_lim);
      if (width < entry_lim)     return PLD_CLEAN;
      else if (width > exit_lim) return PLD_WIDE;
      else                       return PLD_MID;
   endfunction
endpackage

// File: rtl/pld_sync.sv
module pld_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 1) begin : g_bad
         initial $error("pld_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pld_width_meter.sv
module pld_width_meter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   output logic             done_o,
   output logic [CNT_W-1:0] width_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad
         initial $error("pld_width_meter: CNT_W must be at least 2");
      end
   endgenerate

   logic             act_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         cnt_q   <= '0;
         done_o  <= 1'b0;
         width_o <= '0;
      end else begin
         act_q  <= active_i;
         done_o <= 1'b0;
         if (active_i) begin
            if (!act_q)                cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end else if (act_q) begin
            done_o  <= 1'b1;
            width_o <= cnt_q;
            cnt_q   <= '0;
         end
      end
   end

   // R2: a measurement strobe lasts one cycle and always carries a width
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r2_width_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> width_o != '0);
endmodule

// File: rtl/pld_lock_fsm.sv
module pld_lock_fsm
   import pld_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int ENTRY_TICKS = 15,
   parameter int EXIT_TICKS  = 25,
   parameter int NEED_LO     = 3,
   parameter int NEED_HI     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             precise_i,
   input  logic             done_i,
   input  logic [CNT_W-1:0] width_i,
   output logic             lock_o
);
   localparam int RUN_W = $clog2(NEED_HI + 1);
   localparam logic [CNT_W-1:0] ENTRY_W = CNT_W'(ENTRY_TICKS);
   localparam logic [CNT_W-1:0] EXIT_W  = CNT_W'(EXIT_TICKS);

   generate
      if (NEED_LO < 1 || NEED_HI < NEED_LO) begin : g_bad_need
         initial $error("pld_lock_fsm: need 1 <= NEED_LO <= NEED_HI");
      end
      if (ENTRY_TICKS < 1 || EXIT_TICKS < ENTRY_TICKS) begin : g_bad_thr
         initial $error("pld_lock_fsm: need 1 <= ENTRY_TICKS <= EXIT_TICKS");
      end
      if (EXIT_TICKS >= (1 << CNT_W) - 1) begin : g_bad_cnt
         initial $error("pld_lock_fsm: CNT_W too narrow for EXIT_TICKS");
      end
   endgenerate

   pld_verdict_e     verdict;
   logic [RUN_W-1:0] need;
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_inc;
   logic             lock_q;

   always_comb begin
      verdict = pld_classify(int'(width_i), ENTRY_TICKS, EXIT_TICKS);
      need    = precise_i ? RUN_W'(NEED_HI) : RUN_W'(NEED_LO);
      run_inc = run_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         run_q  <= '0;
      end else if (done_i) begin
         if (lock_q) begin
            if (verdict == PLD_WIDE) lock_q <= 1'b0;
            run_q <= '0;
         end else if (verdict == PLD_CLEAN) begin
            if (run_inc >= need) begin
               lock_q <= 1'b1;
               run_q  <= '0;
            end else begin
               run_q <= run_inc;
            end
         end else begin
            run_q <= '0;
         end
      end
   end

   assign lock_o = lock_q;

   // R3: lock may only rise straight after a clean comparison
   a_r3_rise_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(done_i) && ($past(width_i) < ENTRY_W));
   // R6: lock may only fall straight after a comparison over the exit limit
   a_r6_fall_on_wide: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_q) |-> $past(done_i) && ($past(width_i) > EXIT_W));
   // R5: anything not over the exit limit keeps lock
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q && !(done_i && width_i > EXIT_W) |=> lock_q);
   // R7: an unclean comparison while unlocked clears the run
   a_r7_run_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_q && done_i && width_i >= ENTRY_W |=> run_q == '0);
   // R1: the run stays bounded and idle while locked
   a_r1_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q < RUN_W'(NEED_HI)) && (!lock_q || run_q == '0));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8,
   parameter int ENTRY_TICKS = 15,
   parameter int EXIT_TICKS  = 25,
   parameter int NEED_LO     = 3,
   parameter int NEED_HI     = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_i,
   input  logic dn_i,
   input  logic precise_i,
   output logic lock_o
);
   localparam int LANES = 2;

   logic [LANES-1:0] raw;
   logic [LANES-1:0] synced;
   logic             active;
   logic             done;
   logic [CNT_W-1:0] width;

   assign raw = {dn_i, up_i};

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         pld_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (raw[g]),
            .q_o   (synced[g])
         );
      end
   endgenerate

   assign active = |synced;

   pld_width_meter #(.CNT_W(CNT_W)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .done_o   (done),
      .width_o  (width)
   );

   pld_lock_fsm #(
      .CNT_W       (CNT_W),
      .ENTRY_TICKS (ENTRY_TICKS),
      .EXIT_TICKS  (EXIT_TICKS),
      .NEED_LO     (NEED_LO),
      .NEED_HI     (NEED_HI)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .precise_i (precise_i),
      .done_i    (done),
      .width_i   (width),
      .lock_o    (lock_o)
   );

   // R1: reset leaves the output low on the first active cycle
   a_r1_reset_low: assert property (@(posedge clk)
      !rst_n |=> !lock_o);
endmodule

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic up_i = 1'b0;
   logic dn_i = 1'b0;
   logic precise_i = 1'b0;
   logic lock_o;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pll_lock_detect u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_i      (up_i),
      .dn_i      (dn_i),
      .precise_i (precise_i),
      .lock_o    (lock_o)
   );

   task automatic chk(input logic exp, input string req, input string what);
      n_checks++;
      if (lock_o !== exp) begin
         n_fail++;
         $display("FAIL %s %s: lock_o=%b expected %b", req, what, lock_o, exp);
      end
   endtask

   task automatic do_reset(input logic prec);
      @(negedge clk);
      rst_n = 1'b0;
      up_i = 1'b0;
      dn_i = 1'b0;
      precise_i = prec;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // one comparison: up high ticks [us, us+ul), down high [ds, ds+dl)
   task automatic pulse(input int us, input int ul, input int ds, input int dl);
      int total = (us + ul > ds + dl) ? us + ul : ds + dl;
      for (int t = 0; t < total; t++) begin
         up_i = (t >= us) && (t < us + ul);
         dn_i = (t >= ds) && (t < ds + dl);
         @(negedge clk);
      end
      up_i = 1'b0;
      dn_i = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic up_pulse(input int w);
      pulse(0, w, 0, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(1'b0, "R1", "held in reset");
      do_reset(1'b0);
      chk(1'b0, "R1", "after reset");
      up_pulse(5); up_pulse(5);
      do_reset(1'b0);
      up_pulse(5); up_pulse(5);
      chk(1'b0, "R1", "run cleared by reset");
      up_pulse(5);
      chk(1'b1, "R1", "locks after fresh run of three");
   endtask

   task automatic t_coarse;
      do_reset(1'b0);
      up_pulse(3); up_pulse(14);
      chk(1'b0, "R3", "two clean");
      up_pulse(1);
      chk(1'b1, "R3", "three clean");
   endtask

   task automatic t_fine;
      do_reset(1'b1);
      for (int i = 0; i < 4; i++) up_pulse(6);
      chk(1'b0, "R4", "four clean in precise mode");
      up_pulse(6);
      chk(1'b1, "R4", "five clean in precise mode");
   endtask

   task automatic t_hold_and_exit;
      do_reset(1'b0);
      for (int i = 0; i < 3; i++) up_pulse(5);
      up_pulse(20);
      chk(1'b1, "R5", "mid error keeps lock");
      up_pulse(15);
      chk(1'b1, "R5", "error at entry limit keeps lock");
      up_pulse(25);
      chk(1'b1, "R8", "error equal to exit limit keeps lock");
      up_pulse(4);
      chk(1'b1, "R5", "clean keeps lock");
      pulse(0, 0, 0, 26);
      chk(1'b0, "R6", "one error over exit limit drops lock");
      up_pulse(5); up_pulse(5);
      chk(1'b0, "R6", "relock needs a full run");
      up_pulse(5);
      chk(1'b1, "R6", "relocked");
   endtask

   task automatic t_unlocked_restart;
      do_reset(1'b0);
      up_pulse(5); up_pulse(5);
      up_pulse(18);
      up_pulse(5); up_pulse(5);
      chk(1'b0, "R7", "mid error restarts run");
      up_pulse(40);
      up_pulse(5); up_pulse(5);
      chk(1'b0, "R7", "wide error restarts run");
      up_pulse(5);
      chk(1'b1, "R7", "lock after full run");
   endtask

   task automatic t_entry_edge;
      do_reset(1'b0);
      up_pulse(14); up_pulse(14);
      up_pulse(15);
      chk(1'b0, "R8", "width equal to entry limit not clean");
      up_pulse(14); up_pulse(14);
      chk(1'b0, "R8", "run restarted by entry-limit width");
      up_pulse(14);
      chk(1'b1, "R8", "width one below entry limit is clean");
   endtask

   task automatic t_union;
      do_reset(1'b0);
      up_pulse(5); up_pulse(5);
      pulse(0, 10, 5, 12);
      up_pulse(5); up_pulse(5);
      chk(1'b0, "R2", "overlapping up/down union of 17 is not clean");
      pulse(0, 0, 0, 7);
      chk(1'b1, "R2", "down-only pulse counts as clean comparison");
      pulse(0, 20, 10, 20);
      chk(1'b0, "R2", "union of 30 drops lock");
   endtask

   task automatic t_latency;
      do_reset(1'b0);
      up_pulse(5); up_pulse(5);
      up_i = 1'b1;
      repeat (5) @(negedge clk);
      up_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(1'b0, "R9", "no lock at second edge after pulse end");
      @(negedge clk);
      chk(1'b1, "R9", "lock at third edge after pulse end");
      repeat (8) @(negedge clk);
   endtask

   initial begin
      t_reset();
      t_coarse();
      t_fine();
      t_hold_and_exit();
      t_unlocked_restart();
      t_entry_edge();
      t_union();
      t_latency();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule